// File: doc/BRIEF.md
# Multi-Lane TDM Audio Serial Transmitter

This block turns parallel PCM samples into serial audio on up to four data lanes. Every frame it captures eight 32-bit input channels through a per-slot channel selector. It then shifts the chosen samples out MSB first, left-justified in their slots. It also produces the frame clock and a bit clock. The bit rate is paced by an external bit-tick enable: each tick toggles the bit clock, so one bit period lasts two ticks.

One format engine covers three framings. They differ only in whether the data trails the frame clock by one bit, and in how long the frame clock stays asserted. Standard I2S puts two channels on each lane. The two short-pulse modes put every slot of the frame on lane 0. Each lane has a start-pair code that chooses which pair of slots it carries, or silences the lane. Programming the clock generator, the register bus and sample buffering belong to the surrounding subsystem.

Top module: `tdm_tx`

## Requirements
- R1: While `rstN` is low, and in the cycle after any clock edge at which `enable` is low, `serOut` is 0, `frameClk` equals `lrInvert` and `bitClk` equals `bckInvert`. After `enable` rises, transmission restarts at bit 0 of slot 0 with freshly captured samples.
- R2: Each clock edge with `bitTick` high toggles the raw bit clock. `bitClk` is the raw clock XOR `bckInvert`. Data and frame clock advance only on ticks where the raw clock goes from high to low, so each bit lasts two ticks.
- R3: `modeSel` 0 is I2S, 1 is short-pulse with no delay, 2 is short-pulse with one-bit delay, and 3 behaves as 0. Modes 0 and 2 delay the data by one bit period relative to the frame clock. Mode 1 has no delay.
- R4: Let q be the data bit position in the frame and d the delay. The raw frame clock is high when ((q + d) mod frameBits) <= W. W is slot width minus 1 in I2S, which gives a 50% clock, and 0 in the short-pulse modes, which gives a one-bit pulse. `frameClk` is the raw value XOR `lrInvert`.
- R5: `slotCode` 0/1/2/3 gives 16/24/32/32 bits per slot. A frame holds 2 slots in I2S. In the short-pulse modes `chanCode` 0/1/2/3 gives 2/4/8/8 slots.
- R6: `wordLenCode` 1 sends a 16-bit word taken from sample bits 15:0. Any other value sends all 32 bits. The word is sent MSB first from slot bit 0. Slot bits past the word are 0, and word bits past the slot are dropped.
- R7: The lane code c sits at `laneStart[3L+2:3L]`. A code below 4 makes lane L carry slot (2c + s) mod 8 in frame slot s. A code of 4 or more holds the lane at 0.
- R8: In the short-pulse modes (1 and 2), lanes 1 to 3 are always 0.
- R9: Frame slot k carries input channel `slotSel[3k+2:3k]`. Channel n is `samples[32n+31:32n]`.
- R10: Samples are captured at the tick that starts data bit 0 of slot 0. A change to `samples` later in the frame has no effect until the next frame.
- R11: A clock edge with `bitTick` low, while enabled, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds idle levels and restarts the frame |
| bitTick | input | 1 | Bit clock half-period enable |
| modeSel | input | 2 | Framing mode |
| wordLenCode | input | 2 | Word length code |
| slotCode | input | 2 | Slot width code |
| chanCode | input | 2 | Slots per frame code (short-pulse modes) |
| laneStart | input | 12 | Four 3-bit lane start-pair codes |
| lrInvert | input | 1 | Frame clock polarity invert |
| bckInvert | input | 1 | Bit clock polarity invert |
| slotSel | input | 24 | Eight 3-bit channel selectors, one per slot |
| samples | input | 256 | Eight 32-bit PCM channel samples |
| serOut | output | 4 | Serial data lanes |
| frameClk | output | 1 | Frame clock |
| bitClk | output | 1 | Bit clock |

## Verification
A slip in the bit or slot counters moves the frame clock edge relative to the data MSB within one bit period. Every framing is compared position by position over whole frames, so such a slip shows at once. A wrong capture instant or a wrong selector shows as a wrong word in the very next frame. A lane gating error puts ones on a lane that must stay silent from the first bit. Mid-frame sample swaps and tick pauses expose state that changes at the wrong time within one or two ticks.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int NUM_CH        = 8;
  localparam int NUM_LANES     = 4;
  localparam int SMP_W         = 32;
  localparam int MAX_SLOT_BITS = 32;
  localparam int SEL_W         = $clog2(NUM_CH);
  localparam int CODE_W        = SEL_W;
  localparam int BIT_W         = $clog2(MAX_SLOT_BITS);
  localparam int SLOT_W        = $clog2(NUM_CH);
  localparam int FPOS_W        = BIT_W + SLOT_W + 2;

  localparam logic [1:0] MODE_I2S  = 2'd0;
  localparam logic [1:0] MODE_NDLY = 2'd1;
  localparam logic [1:0] MODE_DLY  = 2'd2;

  typedef struct packed {
    logic active;
    logic latch;
  } ctrlStrobe_t;

  function automatic logic isDsp(input logic [1:0] mode);
    return (mode == MODE_NDLY) || (mode == MODE_DLY);
  endfunction

  function automatic logic [BIT_W:0] slotBitsOf(input logic [1:0] code);
    case (code)
      2'd0:    return (BIT_W+1)'(16);
      2'd1:    return (BIT_W+1)'(24);
      default: return (BIT_W+1)'(32);
    endcase
  endfunction

  function automatic logic [SLOT_W:0] slotsOf(input logic [1:0] mode, input logic [1:0] chan);
    if (!isDsp(mode)) return (SLOT_W+1)'(2);
    case (chan)
      2'd0:    return (SLOT_W+1)'(2);
      2'd1:    return (SLOT_W+1)'(4);
      default: return (SLOT_W+1)'(8);
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitTick,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        slotCode,
  input  logic [1:0]        chanCode,
  input  logic              lrInvert,
  input  logic              bckInvert,
  output ctrlStrobe_t       strobe,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [BIT_W-1:0]  bitIdx,
  output logic              frameClk,
  output logic              bitClk
);
  logic              phase;
  logic              started;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [BIT_W:0]    slotBits;
  logic [SLOT_W:0]   nSlots;
  logic              lastBit;
  logic              lastSlot;
  logic              fallTick;

  assign slotBits = slotBitsOf(slotCode);
  assign nSlots   = slotsOf(modeSel, chanCode);
  assign lastBit  = ({1'b0, bitCnt} >= slotBits - 1'b1);
  assign lastSlot = ({1'b0, slotCnt} >= nSlots - 1'b1);
  assign fallTick = bitTick && phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      started <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (!enable) begin
      phase   <= 1'b0;
      started <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (bitTick) begin
      phase <= ~phase;
      if (phase) begin
        if (!started) begin
          started <= 1'b1;
          bitCnt  <= '0;
          slotCnt <= '0;
        end else if (lastBit) begin
          bitCnt  <= '0;
          slotCnt <= lastSlot ? '0 : slotCnt + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.active = started;
    strobe.latch  = enable && fallTick && (!started || (lastBit && lastSlot));
  end

  assign slotIdx = slotCnt;
  assign bitIdx  = bitCnt;

  // frame clock position runs ahead of the data position by the delay
  logic [FPOS_W-1:0] pos, posAhead, frameLen, highWidth;
  logic              rawFrame;

  always_comb begin
    pos       = FPOS_W'(slotCnt) * FPOS_W'(slotBits) + FPOS_W'(bitCnt);
    frameLen  = FPOS_W'(nSlots) * FPOS_W'(slotBits);
    highWidth = isDsp(modeSel) ? '0 : FPOS_W'(slotBits) - 1'b1;
    posAhead  = pos + FPOS_W'(modeSel != MODE_NDLY);
    if (posAhead >= frameLen) posAhead = posAhead - frameLen;
    rawFrame  = started && (posAhead <= highWidth);
  end

  assign frameClk = rawFrame ^ lrInvert;
  assign bitClk   = phase ^ bckInvert;
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_tx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [SLOT_W-1:0]           slotIdx,
  input  logic [BIT_W-1:0]            bitIdx,
  input  logic [1:0]                  modeSel,
  input  logic [1:0]                  wordLenCode,
  input  logic [NUM_LANES*CODE_W-1:0] laneStart,
  input  logic [NUM_CH*SEL_W-1:0]     slotSel,
  input  logic [NUM_CH*SMP_W-1:0]     samples,
  output logic [NUM_LANES-1:0]        serOut
);
  logic [SMP_W-1:0] frameWord [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        frameWord[k] <= '0;
      else if (strobe.latch)
        frameWord[k] <= samples[int'(slotSel[k*SEL_W +: SEL_W])*SMP_W +: SMP_W];
    end
  end

  logic [BIT_W-1:0] wordMsb;
  logic [BIT_W-1:0] bitSel;
  logic             inWord;

  assign wordMsb = (wordLenCode == 2'd1) ? BIT_W'(15) : BIT_W'(SMP_W-1);
  assign inWord  = (bitIdx <= wordMsb);
  assign bitSel  = wordMsb - bitIdx;

  for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
    logic [CODE_W-1:0] code;
    logic [SLOT_W-1:0] pick;
    logic [SMP_W-1:0]  word;
    logic              laneOn;
    logic              laneBit;

    always_comb begin
      code    = laneStart[L*CODE_W +: CODE_W];
      pick    = {code[SLOT_W-2:0], 1'b0} + slotIdx;
      word    = frameWord[pick];
      laneOn  = strobe.active && !code[CODE_W-1] && ((L == 0) || !isDsp(modeSel));
      laneBit = laneOn && inWord && word[bitSel];
    end

    assign serOut[L] = laneBit;
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        bitTick,
  input  logic [1:0]                  modeSel,
  input  logic [1:0]                  wordLenCode,
  input  logic [1:0]                  slotCode,
  input  logic [1:0]                  chanCode,
  input  logic [NUM_LANES*CODE_W-1:0] laneStart,
  input  logic                        lrInvert,
  input  logic                        bckInvert,
  input  logic [NUM_CH*SEL_W-1:0]     slotSel,
  input  logic [NUM_CH*SMP_W-1:0]     samples,
  output logic [NUM_LANES-1:0]        serOut,
  output logic                        frameClk,
  output logic                        bitClk
);
  ctrlStrobe_t       strobe;
  logic [SLOT_W-1:0] slotIdx;
  logic [BIT_W-1:0]  bitIdx;

  tdm_tx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .modeSel(modeSel), .slotCode(slotCode), .chanCode(chanCode),
    .lrInvert(lrInvert), .bckInvert(bckInvert),
    .strobe(strobe), .slotIdx(slotIdx), .bitIdx(bitIdx),
    .frameClk(frameClk), .bitClk(bitClk)
  );

  tdm_tx_path i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx), .bitIdx(bitIdx),
    .modeSel(modeSel), .wordLenCode(wordLenCode), .laneStart(laneStart),
    .slotSel(slotSel), .samples(samples), .serOut(serOut)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        bitTick,
  input logic [1:0]  modeSel,
  input logic [1:0]  wordLenCode,
  input logic [1:0]  slotCode,
  input logic [1:0]  chanCode,
  input logic [11:0] laneStart,
  input logic        lrInvert,
  input logic        bckInvert,
  input logic [3:0]  serOut,
  input logic        frameClk,
  input logic        bitClk
);
  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (serOut == 4'd0) && (frameClk == lrInvert) && (bitClk == bckInvert));

  // R2
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(serOut) && $stable(modeSel) && $stable(wordLenCode) &&
     $stable(slotCode) && $stable(laneStart)) |-> (bitClk == bckInvert));

  // R8
  short_pulse_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 2'd1) || (modeSel == 2'd2)) |-> (serOut[3:1] == 3'd0));

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitTick ##1 ($stable(bckInvert) && $stable(lrInvert) && $stable(modeSel) &&
      $stable(slotCode) && $stable(chanCode) && $stable(laneStart) && $stable(wordLenCode)))
    |-> ($stable(serOut) && $stable(frameClk) && $stable(bitClk)));

  for (genvar L = 0; L < 4; L++) begin : g_lane
    // R7
    lane_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneStart[L*3+2] |-> !serOut[L]);
  end
endmodule

bind tdm_tx tdm_tx_chk i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
  .modeSel(modeSel), .wordLenCode(wordLenCode), .slotCode(slotCode), .chanCode(chanCode),
  .laneStart(laneStart), .lrInvert(lrInvert), .bckInvert(bckInvert),
  .serOut(serOut), .frameClk(frameClk), .bitClk(bitClk)
);

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         bitTick = 1'b1;
  logic [1:0]   modeSel = 2'd0;
  logic [1:0]   wordLenCode = 2'd2;
  logic [1:0]   slotCode = 2'd2;
  logic [1:0]   chanCode = 2'd0;
  logic [11:0]  laneStart = 12'h688;
  logic         lrInvert = 1'b1;
  logic         bckInvert = 1'b0;
  logic [23:0]  slotSel = 24'hFAC688;
  logic [255:0] samples = '0;
  logic [3:0]   serOut;
  logic         frameClk;
  logic         bitClk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdm_tx i_tdm_tx (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  wl;
    logic [1:0]  sc;
    logic [1:0]  cc;
    logic [11:0] lanes;
    logic        lrI;
    logic        bkI;
    logic [23:0] sel;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 2'd2, 2'd0, 12'h688, 1'b0, 1'b0, 24'hFAC688, 16'd1},
    '{2'd0, 2'd1, 2'd0, 2'd2, 12'h920, 1'b0, 1'b0, 24'h053977, 16'd2},
    '{2'd1, 2'd1, 2'd2, 2'd2, 12'h688, 1'b0, 1'b0, 24'hFAC688, 16'd3},
    '{2'd2, 2'd2, 2'd1, 2'd1, 12'h922, 1'b0, 1'b0, 24'h4A3D1E, 16'd4},
    '{2'd0, 2'd2, 2'd2, 2'd0, 12'h113, 1'b1, 1'b1, 24'h053977, 16'd5},
    '{2'd1, 2'd2, 2'd2, 2'd0, 12'h000, 1'b1, 1'b0, 24'hFAC688, 16'd6},
    '{2'd2, 2'd1, 2'd0, 2'd2, 12'h000, 1'b0, 1'b1, 24'h4A3D1E, 16'd7},
    '{2'd0, 2'd1, 2'd1, 2'd3, 12'hEC1, 1'b0, 1'b0, 24'hFAC688, 16'd8},
    '{2'd1, 2'd2, 2'd3, 2'd3, 12'h000, 1'b0, 1'b0, 24'h053977, 16'd9},
    '{2'd3, 2'd0, 2'd1, 2'd0, 12'h688, 1'b1, 1'b0, 24'h4A3D1E, 16'd10}
  };

  function automatic logic [31:0] smp(input int seed, input int ch);
    logic [31:0] v;
    v = (32'(seed) * 32'h9E3779B1) ^ (32'(ch + 1) * 32'h01234567);
    v = v ^ (v >> 13) ^ (v << 7);
    return v;
  endfunction

  function automatic logic [255:0] gen(input int seed);
    logic [255:0] r;
    for (int ch = 0; ch < 8; ch++) r[ch*32 +: 32] = smp(seed, ch);
    return r;
  endfunction

  function automatic int slotBitsM();
    return (slotCode == 2'd0) ? 16 : (slotCode == 2'd1) ? 24 : 32;
  endfunction
  function automatic bit dspM();
    return (modeSel == 2'd1) || (modeSel == 2'd2);
  endfunction
  function automatic int frameBitsM();
    int ns;
    ns = !dspM() ? 2 : (chanCode == 2'd0) ? 2 : (chanCode == 2'd1) ? 4 : 8;
    return ns * slotBitsM();
  endfunction

  function automatic logic expFrame(input int q);
    int d, hw;
    d  = (modeSel == 2'd1) ? 0 : 1;
    hw = dspM() ? 0 : slotBitsM() - 1;
    return logic'(((q + d) % frameBitsM()) <= hw) ^ lrInvert;
  endfunction

  function automatic logic [3:0] expLanes(input int q, input int seed);
    logic [3:0] r;
    int sb, s, b, c, idx, ch, wb;
    logic [31:0] w;
    sb = slotBitsM(); s = q / sb; b = q % sb;
    wb = (wordLenCode == 2'd1) ? 16 : 32;
    for (int L = 0; L < 4; L++) begin
      c = int'(laneStart[L*3 +: 3]);
      if (c >= 4 || (dspM() && L > 0)) r[L] = 1'b0;
      else begin
        idx = (2*c + s) % 8;
        ch  = int'(slotSel[idx*3 +: 3]);
        w   = smp(seed, ch);
        r[L] = (b < wb) ? w[wb-1-b] : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // enter at a negedge with the bit clock in its low phase
  task automatic checkFrame(input int seed, input int swapAt, input int seedNext, input string req);
    int bad, badQ, actV, expV;
    bad = 0; badQ = 0; actV = 0; expV = 0;
    for (int q = 0; q < frameBitsM(); q++) begin
      @(posedge clk); @(negedge clk);
      if (bad == 0 && bitClk !== ~bckInvert) begin
        bad = 1; badQ = q; actV = int'(bitClk); expV = int'(~bckInvert);
      end
      @(posedge clk); @(negedge clk);
      if (bad == 0 && ({frameClk, serOut} !== {expFrame(q), expLanes(q, seed)})) begin
        bad = 1; badQ = q;
        actV = int'({frameClk, serOut}); expV = int'({expFrame(q), expLanes(q, seed)});
      end
      if (q == swapAt) samples = gen(seedNext);
    end
    check(bad == 0, req, $sformatf("frame bit %0d {frameClk,serOut} or bitClk", badQ), actV, expV);
  endtask

  task automatic checkIdle(input string req);
    check((serOut === 4'd0) && (frameClk === lrInvert) && (bitClk === bckInvert), req,
          "idle outputs {serOut,frameClk,bitClk}", int'({serOut, frameClk, bitClk}),
          int'({4'd0, lrInvert, bckInvert}));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      enable      = 1'b0;
      modeSel     = VECS[v].mode;
      wordLenCode = VECS[v].wl;
      slotCode    = VECS[v].sc;
      chanCode    = VECS[v].cc;
      laneStart   = VECS[v].lanes;
      lrInvert    = VECS[v].lrI;
      bckInvert   = VECS[v].bkI;
      slotSel     = VECS[v].sel;
      samples     = gen(int'(VECS[v].seed));
      @(posedge clk); @(negedge clk);
      checkIdle("R1 disabled");
      enable = 1'b1;
      checkFrame(int'(VECS[v].seed), -1, 0, "R3/R4/R5/R6/R7/R8/R9 first frame");
      checkFrame(int'(VECS[v].seed), -1, 0, "R2/R4 steady frame");
    end

    // R10: mid-frame sample swap applies only from next frame
    enable = 1'b0;
    modeSel = 2'd0; wordLenCode = 2'd2; slotCode = 2'd2; chanCode = 2'd0;
    laneStart = 12'h688; lrInvert = 1'b0; bckInvert = 1'b0; slotSel = 24'hFAC688;
    samples = gen(21);
    @(posedge clk); @(negedge clk);
    enable = 1'b1;
    checkFrame(21, 10, 22, "R10 swap held off");
    checkFrame(22, -1, 0, "R10 swap taken next frame");

    // R1: drop enable mid-frame, restart at bit 0 with fresh samples
    repeat (7) @(negedge clk);
    enable = 1'b0;
    samples = gen(23);
    @(posedge clk); @(negedge clk);
    checkIdle("R1 mid-frame disable");
    enable = 1'b1;
    checkFrame(23, -1, 0, "R1 restart");

    // R11: no tick, no change
    begin
      logic [5:0] snap;
      @(posedge clk); @(negedge clk);
      snap = {serOut, frameClk, bitClk};
      bitTick = 1'b0;
      repeat (6) @(negedge clk);
      check({serOut, frameClk, bitClk} === snap, "R11", "outputs during tick pause",
            int'({serOut, frameClk, bitClk}), int'(snap));
      bitTick = 1'b1;
    end

    // R8: short-pulse mode silences lanes 1..3 even with valid codes
    enable = 1'b0;
    modeSel = 2'd2; chanCode = 2'd0; laneStart = 12'h688; samples = gen(31);
    @(posedge clk); @(negedge clk);
    enable = 1'b1;
    checkFrame(31, -1, 0, "R8 short-pulse lanes");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule